// File: doc/BRIEF.md
# Line-Change Timestamp Capture Engine

This block watches a wide group of asynchronous input lines, organised as 32-bit slices, and records the moment each enabled line changes level. Each line first passes through a synchroniser. An edge detector then compares the synchronised level with the level from the previous cycle, so both rising and falling changes are caught. When a change is seen, the block latches the current value of a free-running 64-bit system counter into that line's pending slot. Pending slots drain into a 256-entry record FIFO, one per cycle, lowest line index first. Each record carries the timestamp, the line index and the new level.

Software reads records through a valid/ready output stream. A record is valid whenever the FIFO is not empty, and the consumer takes it by raising ready. Holding ready low is the only back-pressure the block accepts. Capture never stalls: events that find the FIFO full are discarded and counted as overflow. Enable bits are written one slice at a time.

A single level-sensitive interrupt is asserted while FIFO occupancy is at or above a programmable threshold.

Top module: `linechg_stamp`

## Requirements
- R1: Each line passes through two synchroniser flops and then an edge detector. A level change applied before rising edge k is captured at edge k+2 with the value of `ts_count_i` present at that edge. The record appears on the output after edge k+3 when no other line is ahead of it. Rising and falling changes are both captured.
- R2: Enable bit b of slice s controls line 32*s+b. A write with `en_wr_i` high replaces all 32 bits of slice `en_slice_i` with `en_data_i`. A write to a slice index of NUM_SLICES or above changes nothing. All enables are clear after reset. A change on a disabled line creates no record.
- R3: The output record shows the 64-bit captured timestamp on `rec_ts_o`, the line index on `rec_line_o`, and the level after the change on `rec_level_o`.
- R4: Lines that change in the same cycle each keep their own pending slot with the same timestamp. The slots enter the FIFO in ascending line order, at most one per cycle.
- R5: The FIFO holds 256 records in arrival order. `rec_valid_o` is high exactly when it is non-empty. A record is removed on a cycle where both `rec_valid_o` and `rec_ready_i` are high. Ready while the FIFO is empty has no effect.
- R6: A pending record that drains while the FIFO holds 256 entries is discarded and sets `overflow_o`. `overflow_o` stays set until a cycle where `ovf_clr_i` is high and no new loss occurs. A loss in the same cycle as a clear wins.
- R7: A change on a line whose pending slot is still occupied, and is not draining in that cycle, is discarded and sets `overflow_o`.
- R8: The threshold resets to 1. A write with `thr_wr_i` loads `thr_data_i`, with 0 taken as 1 and values above 256 taken as 256. `irq_o` is high exactly while occupancy is at or above the threshold.
- R9: `fifo_count_o` reports the number of records held in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | 32*NUM_SLICES | Monitored asynchronous lines |
| ts_count_i | input | 64 | Free-running system counter |
| en_wr_i | input | 1 | Enable slice write strobe |
| en_slice_i | input | clog2(NUM_SLICES) | Slice selected for the enable write |
| en_data_i | input | 32 | New enable bits for the selected slice |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_data_i | input | clog2(FIFO_DEPTH+1) | Threshold value to load |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| rec_valid_o | output | 1 | Head record available |
| rec_ready_i | input | 1 | Consumer takes the head record |
| rec_ts_o | output | 64 | Head record timestamp |
| rec_line_o | output | clog2(32*NUM_SLICES) | Head record line index |
| rec_level_o | output | 1 | Head record new level |
| fifo_count_o | output | clog2(FIFO_DEPTH+1) | FIFO occupancy |
| overflow_o | output | 1 | Sticky loss flag |
| irq_o | output | 1 | Occupancy at or above threshold |

## Verification
The assertions assume that `rec_ready_i` and `ovf_clr_i` are ordinary synchronous inputs that may be raised at any time. Under that assumption, occupancy never exceeds the depth and never moves by more than one record per cycle. The stimulus changes `lines_i` only at falling clock edges, so the synchroniser delay is deterministic and the bench model can predict the capture edge exactly. Bursts of changes are spaced so that slots either drain cleanly or collide on purpose. The FIFO is deliberately filled past its depth with ready held low, so every loss path is reached.

// File: rtl/linechg_pkg.sv
package linechg_pkg;
  localparam int TS_W    = 64;
  localparam int SLICE_W = 32;

  // Timestamp and post-change level captured for one line.
  typedef struct packed {
    logic [TS_W-1:0] ts;
    logic            lvl;
  } stamp_t;
endpackage

// File: rtl/linechg_sync.sv
// Multi-stage synchroniser followed by a level-change detector, one lane per line.
module linechg_sync #(
  parameter int N      = 96,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] change_o
);
  logic [STAGES-1:0][N-1:0] stg_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= lines_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[k] <= '0;
      else         stg_q[k] <= stg_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign level_o  = stg_q[STAGES-1];
  assign change_o = stg_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/linechg_pend.sv
// Per-line pending slots with lowest-index-first drain.
module linechg_pend
  import linechg_pkg::*;
#(
  parameter int N     = 96,
  parameter int IDX_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      change_i,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      enable_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              grant_valid_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output stamp_t            grant_stamp_o,
  output logic              clash_o
);
  logic [N-1:0] pend_q;
  stamp_t       slot_q [N];
  logic [N-1:0] gnt;
  logic [N-1:0] cap;
  logic [N-1:0] hit;
  logic         pick_v;
  logic [IDX_W-1:0] pick_idx;

  // Scan downward so the lowest pending index is the one left standing.
  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_v   = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (pick_v) gnt[pick_idx] = 1'b1;
  end

  assign hit     = change_i & enable_i;
  assign cap     = hit & (~pend_q | gnt);
  assign clash_o = |(hit & pend_q & ~gnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~gnt) | cap;
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (cap[i]) slot_q[i] <= '{ts: ts_i, lvl: level_i[i]};
    end
  end

  assign grant_valid_o = pick_v;
  assign grant_idx_o   = pick_idx;
  assign grant_stamp_o = slot_q[pick_idx];
endmodule

// File: rtl/linechg_fifo.sv
// Record FIFO: drops the write when full, reports the drop.
module linechg_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 72,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          full, acc, take;

  assign full   = (count_q == CW'(DEPTH));
  assign acc    = push_i & ~full;
  assign drop_o = push_i & full;
  assign take   = pop_i & (count_q != '0);

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (acc)  wptr_q <= wrap_inc(wptr_q);
      if (take) rptr_q <= wrap_inc(rptr_q);
      count_q <= count_q + CW'(acc) - CW'(take);
    end
  end

  always_ff @(posedge clk_i) begin
    if (acc) mem[wptr_q] <= data_i;
  end

  assign data_o  = mem[rptr_q];
  assign valid_o = (count_q != '0);
  assign count_o = count_q;
endmodule

// File: rtl/linechg_stamp.sv
module linechg_stamp
  import linechg_pkg::*;
#(
  parameter int NUM_SLICES  = 3,
  parameter int FIFO_DEPTH  = 256,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LINES  = NUM_SLICES * SLICE_W,
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [TS_W-1:0]      ts_count_i,
  input  logic                 en_wr_i,
  input  logic [SEL_W-1:0]     en_slice_i,
  input  logic [SLICE_W-1:0]   en_data_i,
  input  logic                 thr_wr_i,
  input  logic [CNT_W-1:0]     thr_data_i,
  input  logic                 ovf_clr_i,
  output logic                 rec_valid_o,
  input  logic                 rec_ready_i,
  output logic [TS_W-1:0]      rec_ts_o,
  output logic [IDX_W-1:0]     rec_line_o,
  output logic                 rec_level_o,
  output logic [CNT_W-1:0]     fifo_count_o,
  output logic                 overflow_o,
  output logic                 irq_o
);
  localparam int REC_W = IDX_W + TS_W + 1;

  logic [NUM_LINES-1:0] level, change, en_vec;
  logic                 g_valid, clash, drop;
  logic [IDX_W-1:0]     g_idx;
  stamp_t               g_stamp, h_stamp;
  logic [REC_W-1:0]     head;
  logic [CNT_W-1:0]     thr_q;
  logic                 ovf_q;

  linechg_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .lines_i(lines_i),
    .level_o(level), .change_o(change)
  );

  // Enable bitmap, one register per 32-line slice.
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [SLICE_W-1:0] en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  en_q <= '0;
      else if (en_wr_i && en_slice_i == SEL_W'(s))  en_q <= en_data_i;
    end
    assign en_vec[s*SLICE_W +: SLICE_W] = en_q;
  end

  linechg_pend #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .change_i(change), .level_i(level), .enable_i(en_vec), .ts_i(ts_count_i),
    .grant_valid_o(g_valid), .grant_idx_o(g_idx), .grant_stamp_o(g_stamp),
    .clash_o(clash)
  );

  linechg_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(g_valid), .data_i({g_idx, g_stamp}),
    .pop_i(rec_ready_i), .data_o(head), .valid_o(rec_valid_o),
    .count_o(fifo_count_o), .drop_o(drop)
  );

  assign {rec_line_o, h_stamp} = head;
  assign rec_ts_o    = h_stamp.ts;
  assign rec_level_o = h_stamp.lvl;

  // Threshold register, clamped into 1..FIFO_DEPTH.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= CNT_W'(1);
    else if (thr_wr_i) begin
      if (thr_data_i == '0)                   thr_q <= CNT_W'(1);
      else if (thr_data_i > CNT_W'(FIFO_DEPTH)) thr_q <= CNT_W'(FIFO_DEPTH);
      else                                    thr_q <= thr_data_i;
    end
  end

  // Sticky loss flag: a new loss beats a clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ovf_q <= 1'b0;
    else if (drop || clash) ovf_q <= 1'b1;
    else if (ovf_clr_i)     ovf_q <= 1'b0;
  end

  assign overflow_o = ovf_q;
  assign irq_o      = (fifo_count_o >= thr_q);
endmodule

// File: rtl/linechg_stamp_chk.sv
module linechg_stamp_chk #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [CNT_W-1:0] fifo_count_o,
  input logic             overflow_o,
  input logic             ovf_clr_i,
  input logic             irq_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fifo_count_o) <= DEPTH); // R5

  AST_EMPTY_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_o == '0) |-> !rec_valid_o); // R5

  AST_POP_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_ready_i) |=> (fifo_count_o <= $past(fifo_count_o))); // R5

  AST_ONE_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fifo_count_o) <= int'($past(fifo_count_o)) + 1) &&
    (int'(fifo_count_o) + 1 >= int'($past(fifo_count_o)))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(overflow_o) && !$past(ovf_clr_i)) |-> overflow_o); // R6

  AST_NO_IRQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_o == '0) |-> !irq_o); // R8
endmodule

bind linechg_stamp linechg_stamp_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rec_valid_o(rec_valid_o),
  .rec_ready_i(rec_ready_i), .fifo_count_o(fifo_count_o),
  .overflow_o(overflow_o), .ovf_clr_i(ovf_clr_i), .irq_o(irq_o)
);

// File: tb/linechg_stamp_tb.sv
module linechg_stamp_tb_top;
  localparam int NS = 3;
  localparam int NL = NS * 32;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [63:0]   ts_cnt = 64'h0000_1234_0000_0000;
  logic          en_wr = 1'b0;
  logic [1:0]    en_slice = '0;
  logic [31:0]   en_data = '0;
  logic          thr_wr = 1'b0;
  logic [8:0]    thr_data = '0;
  logic          ovf_clr = 1'b0;
  logic          rdy = 1'b0;
  logic          r_valid, r_level, ovf, irq;
  logic [63:0]   r_ts;
  logic [6:0]    r_line;
  logic [8:0]    cnt;

  int vectors = 0;
  int miscompares = 0;
  string phase = "reset";

  always #10 clk = ~clk;

  linechg_stamp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .ts_count_i(ts_cnt),
    .en_wr_i(en_wr), .en_slice_i(en_slice), .en_data_i(en_data),
    .thr_wr_i(thr_wr), .thr_data_i(thr_data), .ovf_clr_i(ovf_clr),
    .rec_valid_o(r_valid), .rec_ready_i(rdy), .rec_ts_o(r_ts),
    .rec_line_o(r_line), .rec_level_o(r_level), .fifo_count_o(cnt),
    .overflow_o(ovf), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { longint unsigned ts; int line; bit lvl; } rec_t;
  rec_t q[$];
  bit m_s1[NL], m_s2[NL], m_pv[NL], m_pd[NL], m_en[NL], m_plv[NL];
  longint unsigned m_pts[NL];
  int m_thr;
  bit m_ovf;

  always @(posedge clk or negedge rst_n) begin
    int g, old;
    bit lost;
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < NL; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_pd[i] = 0; m_en[i] = 0;
      end
      m_thr = 1; m_ovf = 0;
    end else begin
      g = -1; lost = 0; old = q.size();
      for (int i = 0; i < NL; i++) if (m_pd[i] && g < 0) g = i;
      if (g >= 0) begin
        if (old == DEPTH) lost = 1;
        else q.push_back('{ts: m_pts[g], line: g, lvl: m_plv[g]});
        m_pd[g] = 0;
      end
      if (rdy && old > 0) void'(q.pop_front());
      for (int i = 0; i < NL; i++) begin
        if (m_s2[i] != m_pv[i] && m_en[i]) begin
          if (m_pd[i]) lost = 1;
          else begin m_pd[i] = 1; m_pts[i] = ts_cnt; m_plv[i] = m_s2[i]; end
        end
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = lines[i];
      end
      if (en_wr && int'(en_slice) < NS)
        for (int b = 0; b < 32; b++) m_en[int'(en_slice)*32 + b] = en_data[b];
      if (thr_wr) m_thr = (thr_data == 0) ? 1 : (int'(thr_data) > DEPTH ? DEPTH : int'(thr_data));
      if (lost) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    end
  end

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R9", "count", cnt, q.size());
    chk("R5", "valid", r_valid, q.size() > 0);
    chk("R8", "irq", irq, q.size() >= m_thr);
    chk("R6", "overflow", ovf, m_ovf);
    if (q.size() > 0) begin
      chk("R3", "ts", r_ts, q[0].ts);
      chk("R3", "line", r_line, q[0].line);
      chk("R3", "level", r_level, q[0].lvl);
    end
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
      ts_cnt = ts_cnt + 64'd1;
      en_wr = 0; thr_wr = 0; ovf_clr = 0;
    end
  endtask

  task automatic write_en(int s, logic [31:0] d);
    en_wr = 1; en_slice = 2'(s); en_data = d; step();
  endtask

  task automatic write_thr(int v);
    thr_wr = 1; thr_data = 9'(v); step();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    longint unsigned t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    phase = "R9 reset state";
    chk("R9", "count after reset", cnt, 0);
    chk("R8", "irq after reset", irq, 0);
    chk("R5", "valid after reset", r_valid, 0);

    // R2: disabled lines create nothing; slice index 3 is ignored
    phase = "R2 disabled";
    write_en(3, 32'hFFFF_FFFF);
    lines[5] = 1; step(6);
    chk("R2", "no record from disabled line", cnt, 0);
    lines[5] = 0; step(6);
    write_en(0, 32'hFFFF_FFFF);
    write_en(1, 32'h0000_00F0);
    write_en(2, 32'hFFFF_FFFF);

    // R1: one rising edge, exact capture timing
    phase = "R1 single edge";
    lines[5] = 1; t0 = ts_cnt;
    step(3);
    chk("R1", "not yet recorded", r_valid, 0);
    step();
    chk("R1", "recorded after 4 edges", r_valid, 1);
    chk("R1", "capture timestamp", r_ts, t0 + 2);
    chk("R1", "line index", r_line, 5);
    chk("R1", "new level", r_level, 1);
    lines[5] = 0; step(5);
    chk("R1", "falling edge recorded too", cnt, 2);
    rdy = 1; step(3); rdy = 0;

    // R4: simultaneous changes, ascending drain; line 40 disabled (R2)
    phase = "R4 simultaneous";
    lines[95] = 1; lines[2] = 1; lines[37] = 1; lines[40] = 1;
    step(7);
    chk("R4", "three records", cnt, 3);
    chk("R4", "lowest first", r_line, 2);
    rdy = 1; step(4); rdy = 0;

    // R7: line 70 toggles while its slot waits behind lines 64..69
    phase = "R7 slot clash";
    for (int i = 64; i < 70; i++) lines[i] = 1;
    lines[70] = 1; step();
    lines[70] = 0; step();
    lines[70] = 1; step(10);
    chk("R7", "clash sets overflow", ovf, 1);
    ovf_clr = 1; step();
    rdy = 1; step(12); rdy = 0;

    // R8: threshold and clamping
    phase = "R8 threshold";
    write_thr(3);
    lines[10] = 1; lines[11] = 1; step(6);
    chk("R8", "below threshold", irq, 0);
    lines[12] = 1; step(6);
    chk("R8", "at threshold", irq, 1);
    write_thr(0);
    write_thr(400);
    chk("R8", "clamped to depth", irq, 0);
    rdy = 1; step(4); rdy = 0;
    write_thr(1);

    // R6: fill past the depth with ready low
    phase = "R6 fill";
    for (int r = 0; r < 5; r++) begin
      lines = ~lines; step(75);
    end
    chk("R6", "full count", cnt, DEPTH);
    chk("R6", "overflow after loss", ovf, 1);
    ovf_clr = 1; step();
    chk("R6", "overflow cleared", ovf, 0);

    // R5: drain everything, including a push while popping
    phase = "R5 drain";
    rdy = 1; lines[0] = ~lines[0];
    step(300);
    chk("R5", "empty after drain", cnt, 0);
    step(3);
    rdy = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule